// File: doc/BRIEF.md
# Interrupt Thread Context Acknowledge Logic

This block holds the interrupt presentation state of one processor thread. Interrupt sources reach it through a simple input port. Each arrival carries a priority from 0 to 7, where a lower number is more urgent, and an exception kind. The block keeps one pending bit for each priority and remembers the kind of each pending priority. It compares the most urgent pending priority with the thread's current processor priority (CPPR). When the pending priority is numerically lower than CPPR, the thread is notified.

The owning thread uses a small byte-addressed window. It writes CPPR to choose which priorities it accepts, and it can read a status byte, CPPR, the pending bitmap and the most urgent pending priority. A 16-bit read at a fixed offset is the acknowledge. It returns the exception kind in the two top bits and the accepted priority in the low byte, and in the same access it retires that pending priority. The usual sequence is: acknowledge, write the returned priority into CPPR, service the interrupt, then write 0xFF to CPPR to go back to idle.

Top module: `irq_ctx_ack`

## Requirements
- R1: After reset the pending bitmap is 0x00, CPPR is 0x00, the status byte is 0x00 and the most-urgent-pending byte reads 0xFF.
- R2: An arrival with a nonzero kind (1 pool, 2 physical, 3 level-sensitive) and priority p sets bit p of the pending bitmap, read at offset 0x02, and records the kind for p. An arrival whose kind is 0 is ignored.
- R3: The byte at offset 0x07 holds the lowest-numbered pending priority, or 0xFF when no priority is pending.
- R4: A write at offset 0x01 loads CPPR, which reads back at 0x01. Writes to any other offset change no state.
- R5: The thread is notified only when the most urgent pending priority is numerically lower than CPPR. When it is notified, the status byte at 0x00 holds the kind of that priority in bits 7:6 and zeros below. Otherwise the status byte is 0x00.
- R6: While the thread is notified, a read at offset 0x800 returns {kind, 6'b0, priority} and clears that priority's pending bit. The byte at 0x07 then moves to the next pending priority, or to 0xFF.
- R7: A read at 0x800 while the thread is not notified returns 0x00FF and changes no state. This includes the case where priorities are pending but are masked by CPPR.
- R8: An arrival at the same priority that an acknowledge retires in the same cycle leaves that bit set, carrying the new kind.
- R9: Reads at any offset other than 0x800 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Interrupt arrival strobe |
| src_prio | input | 3 | Priority of the arriving interrupt |
| src_kind | input | 2 | Exception kind of the arrival (0 means no event) |
| req | input | 1 | Window access request |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data, valid in the same cycle as a read request |

## Verification
The bench targets these corner cases:
- **Pending priority equal to CPPR.** The comparison is strict. A design that used "less or equal" would acknowledge priority 5 while CPPR is 5.
- **Masked acknowledge.** An acknowledge while priorities are pending but masked must return 0x00FF and leave them intact. A design that cleared the bit anyway would lose those interrupts.
- **Draining several priorities.** Retiring priorities one by one exposes an encoder that picks the highest number instead of the lowest, or that fails to fall back to 0xFF when the bitmap is empty.
- **Clear and set in the same cycle.** An arrival at the priority being retired in that cycle exposes a design that lets the clear win, which drops the new interrupt.
- **Stray accesses.** A kind-0 arrival, a write to the bitmap offset, and repeated plain reads must all leave the state unchanged.

// File: rtl/irq_ctx_ack.sv
module irq_ctx_ack #(
  parameter int NPRIO = 8,
  parameter int AW    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_valid,
  input  logic [$clog2(NPRIO)-1:0]   src_prio,
  input  logic [1:0]                 src_kind,
  input  logic                       req,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [7:0]                 wdata,
  output logic [15:0]                rdata
);
  localparam int PW = $clog2(NPRIO);
  localparam logic [AW-1:0] OFF_STAT = AW'(12'h000);
  localparam logic [AW-1:0] OFF_CPPR = AW'(12'h001);
  localparam logic [AW-1:0] OFF_PEND = AW'(12'h002);
  localparam logic [AW-1:0] OFF_TOP  = AW'(12'h007);
  localparam logic [AW-1:0] OFF_ACK  = AW'(12'h800);

  logic [NPRIO-1:0] ipb;
  logic [7:0]       cppr;
  logic [1:0]       kind_q [NPRIO];
  logic [PW-1:0]    top;

  always_comb begin
    top = '0;
    for (int i = NPRIO - 1; i >= 0; i--)
      if (ipb[i]) top = PW'(i);
  end

  wire       any      = |ipb;
  wire [7:0] pipr     = any ? 8'(top) : 8'hFF;
  wire       notify   = any && (pipr < cppr);
  wire [1:0] top_kind = kind_q[top];
  wire       rd       = req && !we;
  wire       take     = rd && (addr == OFF_ACK) && notify;
  wire       arrive   = src_valid && (src_kind != 2'd0);
  wire [7:0] stat     = notify ? {top_kind, 6'b0} : 8'h00;

  wire [NPRIO-1:0] clr = take   ? (NPRIO'(1) << top)      : '0;
  wire [NPRIO-1:0] set = arrive ? (NPRIO'(1) << src_prio) : '0;

  always_comb begin
    rdata = 16'h0000;
    if (rd) begin
      case (addr)
        OFF_STAT: rdata = {8'h00, stat};
        OFF_CPPR: rdata = {8'h00, cppr};
        OFF_PEND: rdata = {8'h00, 8'(ipb)};
        OFF_TOP:  rdata = {8'h00, pipr};
        OFF_ACK:  rdata = notify ? {top_kind, 6'b0, pipr} : 16'h00FF;
        default:  rdata = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipb  <= '0;
      cppr <= 8'h00;
      for (int i = 0; i < NPRIO; i++) kind_q[i] <= 2'd0;
    end else begin
      ipb <= (ipb & ~clr) | set;
      if (arrive) kind_q[src_prio] <= src_kind;
      if (req && we && addr == OFF_CPPR) cppr <= wdata;
    end
  end
endmodule

// File: rtl/irq_ctx_ack_chk.sv
module irq_ctx_ack_chk #(
  parameter int NPRIO = 8,
  parameter int AW    = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     src_valid,
  input logic [$clog2(NPRIO)-1:0] src_prio,
  input logic [1:0]               src_kind,
  input logic                     req,
  input logic                     we,
  input logic [AW-1:0]            addr,
  input logic [7:0]               wdata,
  input logic [15:0]              rdata,
  input logic [NPRIO-1:0]         ipb,
  input logic [7:0]               cppr
);
  localparam int PW = $clog2(NPRIO);
  wire ack_rd = req && !we && (addr == AW'(12'h800));
  wire arr    = src_valid && (src_kind != 2'd0);

  assert_arrival_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr |=> ipb[$past(src_prio)]);

  assert_cppr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == AW'(12'h001)) |=> cppr == $past(wdata));

  assert_ack_below_cppr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && rdata[15:14] != 2'd0) |-> rdata[7:0] < cppr);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && rdata[15:14] != 2'd0 && !(arr && src_prio == rdata[PW-1:0]))
      |=> !ipb[$past(rdata[PW-1:0])]);

  assert_idle_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && rdata == 16'h00FF && !arr) |=> $stable(ipb));
endmodule

bind irq_ctx_ack irq_ctx_ack_chk #(.NPRIO(NPRIO), .AW(AW)) u_chk (.*);

// File: tb/sim_irq_ctx_ack.sv
module sim_irq_ctx_ack;
  logic clk = 0, rst_n = 0;
  logic src_valid = 0; logic [2:0] src_prio = 0; logic [1:0] src_kind = 0;
  logic req = 0, we = 0; logic [11:0] addr = 0; logic [7:0] wdata = 0;
  logic [15:0] rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_ctx_ack u0 (.*);

  // prio(3) kind(2) cppr(8) expected ack(16)
  localparam logic [28:0] VEC [6] = '{
    {3'd3, 2'd2, 8'hFF, 16'h8003},
    {3'd0, 2'd1, 8'hFF, 16'h4000},
    {3'd7, 2'd3, 8'hFF, 16'hC007},
    {3'd5, 2'd2, 8'h05, 16'h00FF},
    {3'd5, 2'd2, 8'h06, 16'h8005},
    {3'd2, 2'd3, 8'h00, 16'h00FF}
  };

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic src(logic [2:0] p, logic [1:0] k);
    @(negedge clk); src_valid = 1; src_prio = p; src_kind = k;
    @(negedge clk); src_valid = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(12'h000, v); chk("R1 status", v, 16'h0000);
    rd(12'h001, v); chk("R1 cppr", v, 16'h0000);
    rd(12'h002, v); chk("R1 pending", v, 16'h0000);
    rd(12'h007, v); chk("R1 top", v, 16'h00FF);

    for (int i = 0; i < 6; i++) begin
      src(VEC[i][28:26], VEC[i][25:24]);
      wr(12'h001, VEC[i][23:16]);
      rd(12'h800, v); chk("R6 table ack", v, VEC[i][15:0]);
      wr(12'h001, 8'hFF);
      rd(12'h800, v);
      rd(12'h002, v); chk("R6 table drained", v, 16'h0000);
    end

    // several pending, masked then opened
    src(3'd4, 2'd3); src(3'd1, 2'd1); src(3'd6, 2'd2);
    rd(12'h002, v); chk("R2 bitmap", v, 16'h0052);
    rd(12'h007, v); chk("R3 top", v, 16'h0001);
    rd(12'h007, v); chk("R9 repeat read", v, 16'h0001);
    wr(12'h001, 8'h01);
    rd(12'h000, v); chk("R5 masked status", v, 16'h0000);
    rd(12'h800, v); chk("R7 masked ack", v, 16'h00FF);
    rd(12'h002, v); chk("R7 bitmap kept", v, 16'h0052);
    wr(12'h002, 8'h00);
    rd(12'h002, v); chk("R4 stray write", v, 16'h0052);
    wr(12'h001, 8'hFF);
    rd(12'h001, v); chk("R4 cppr readback", v, 16'h00FF);
    rd(12'h000, v); chk("R5 status kind", v, 16'h0040);
    rd(12'h800, v); chk("R6 ack p1", v, 16'h4001);
    rd(12'h007, v); chk("R6 next top", v, 16'h0004);
    rd(12'h800, v); chk("R6 ack p4", v, 16'hC004);
    rd(12'h800, v); chk("R6 ack p6", v, 16'h8006);
    rd(12'h007, v); chk("R3 empty top", v, 16'h00FF);
    rd(12'h800, v); chk("R7 empty ack", v, 16'h00FF);

    // kind 0 ignored
    src(3'd3, 2'd0);
    rd(12'h002, v); chk("R2 kind0 ignored", v, 16'h0000);

    // same-cycle clear and set
    src(3'd2, 2'd1);
    @(negedge clk); req = 1; we = 0; addr = 12'h800;
    src_valid = 1; src_prio = 3'd2; src_kind = 2'd3;
    #1 v = rdata; chk("R8 ack value", v, 16'h4002);
    @(negedge clk); req = 0; src_valid = 0;
    rd(12'h002, v); chk("R8 bit kept", v, 16'h0004);
    rd(12'h800, v); chk("R8 new kind", v, 16'hC002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule